// File: doc/BRIEF.md
# Bus Device Reset-and-Address Sequencer

This block brings one target device on a single-wire multi-drop bus to the point where it accepts a function command. On a start pulse it asks a separate reset/byte engine for a bus reset. If a device answers with presence, it then asks the engine to send the addressing bytes. What it sends depends on how many devices share the bus and on the mode requested. When several devices share the bus, a match command followed by the 64-bit device identifier picks one of them. When one device is alone, a single skip command reaches it. Resume mode re-addresses the device that was matched most recently, so the identifier does not have to be sent again.

The engine is driven through a simple handshake. Each request is a one-cycle pulse that carries an operation type and, for byte operations, a data byte. The engine answers with a one-cycle done pulse, which for a reset also carries the sampled presence level. Bit timing on the wire and device discovery belong to the engine and to other logic. At the end of the sequence the block raises a one-cycle done pulse, together with an error flag that reports a missing presence answer.

Top module: `bus_addr_seq`

## Requirements
- R1: The first request of every sequence is a reset (eng_op_o = 0). Byte requests carry eng_op_o = 1.
- R2: If the reset completes with eng_presence_i low, the sequence ends with done_o and err_o both high, and no byte request is issued.
- R3: In select mode (mode_i = 0) with a device count of exactly 1, the only byte sent is 0xCC.
- R4: In select mode with any other device count (0 or 2 and above), nine bytes are sent. The first is 0x55, followed by dev_id_i[7:0], dev_id_i[15:8] and so on up to dev_id_i[63:56].
- R5: In resume mode (mode_i = 1), a single byte is sent: 0xA5 when the device count is above 1, otherwise 0xCC.
- R6: Mode, count and identifier are captured on the accepted start pulse. A start pulse while a sequence is running is ignored.
- R7: At most one request is outstanding. The next request is issued only after eng_done_i, every request is a one-cycle pulse, and eng_done_i with no outstanding request has no effect.
- R8: After reset done_o, err_o and eng_req_o are low. done_o pulses for exactly one cycle when a sequence ends. err_o is low on success, is valid with done_o, and holds until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start a sequence (accepted when idle) |
| mode_i | input | 1 | 0 = select, 1 = resume |
| dev_count_i | input | CNT_W | Number of devices on the bus |
| dev_id_i | input | 8*ID_BYTES | Target device identifier |
| eng_req_o | output | 1 | One-cycle request to the engine |
| eng_op_o | output | 1 | 0 = bus reset, 1 = send byte |
| eng_byte_o | output | 8 | Byte to send |
| eng_done_i | input | 1 | Engine finished the current request |
| eng_presence_i | input | 1 | Presence level, valid with eng_done_i after a reset |
| done_o | output | 1 | One-cycle end-of-sequence pulse |
| err_o | output | 1 | No presence detected (valid with done_o) |

## Verification
The bench builds the block with CNT_W = 8 and ID_BYTES = 8. An 8-bit count reaches the extremes 0 and 255, which exercise both sides of the single-device test in each mode. The full 8-byte identifier checks the lowest-byte-first order across every lane of the byte selector. The engine model's latency is varied so that the wait-for-done behaviour is observed with both short and long engine turnarounds.

// File: rtl/bus_addr_seq_pkg.sv
package bus_addr_seq_pkg;

  localparam logic [7:0] CMD_SKIP   = 8'hCC;
  localparam logic [7:0] CMD_MATCH  = 8'h55;
  localparam logic [7:0] CMD_RESUME = 8'hA5;

  localparam logic OP_RESET = 1'b0;
  localparam logic OP_BYTE  = 1'b1;

  localparam logic MODE_SELECT = 1'b0;
  localparam logic MODE_RESUME = 1'b1;

  typedef enum logic [1:0] {
    ST_IDLE      = 2'd0,
    ST_WAIT_RST  = 2'd1,
    ST_WAIT_BYTE = 2'd2
  } seq_state_e;

endpackage

// File: rtl/bus_addr_plan.sv
module bus_addr_plan
  import bus_addr_seq_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             mode_i,
  input  logic [CNT_W-1:0] count_i,
  output logic [7:0]       cmd_o,
  output logic             send_id_o
);

  logic single_dev;
  logic many_dev;

  assign single_dev = (count_i == CNT_W'(1));
  assign many_dev   = (count_i > CNT_W'(1));

  always_comb begin
    cmd_o     = CMD_SKIP;
    send_id_o = 1'b0;
    if (mode_i == MODE_RESUME) begin
      if (many_dev) cmd_o = CMD_RESUME;
    end else if (!single_dev) begin
      cmd_o     = CMD_MATCH;
      send_id_o = 1'b1;
    end
  end

endmodule

// File: rtl/bus_addr_byte_pick.sv
module bus_addr_byte_pick #(
  parameter int ID_BYTES = 8,
  parameter int IDX_W    = 4
) (
  input  logic [7:0]            cmd_i,
  input  logic [8*ID_BYTES-1:0] id_i,
  input  logic [IDX_W-1:0]      idx_i,
  output logic [7:0]            byte_o
);

  localparam int LANES = ID_BYTES + 1;

  logic [7:0] lanes [LANES];

  assign lanes[0] = cmd_i;

  for (genvar k = 1; k < LANES; k++) begin : g_lane
    assign lanes[k] = id_i[8*(k-1) +: 8];
  end

  always_comb begin
    byte_o = '0;
    for (int k = 0; k < LANES; k++) begin
      if (idx_i == IDX_W'(k)) byte_o = lanes[k];
    end
  end

endmodule

// File: rtl/bus_addr_ctrl.sv
module bus_addr_ctrl
  import bus_addr_seq_pkg::*;
#(
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic             eng_done_i,
  input  logic             eng_presence_i,
  input  logic [IDX_W-1:0] last_idx_i,
  input  logic [7:0]       pick_byte_i,
  output logic [IDX_W-1:0] nxt_idx_o,
  output logic             idle_o,
  output logic             eng_req_o,
  output logic             eng_op_o,
  output logic [7:0]       eng_byte_o,
  output logic             done_o,
  output logic             err_o
);

  seq_state_e       state;
  logic [IDX_W-1:0] idx;

  assign idle_o    = (state == ST_IDLE);
  assign nxt_idx_o = (state == ST_WAIT_BYTE) ? idx + IDX_W'(1) : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      idx        <= '0;
      eng_req_o  <= 1'b0;
      eng_op_o   <= OP_RESET;
      eng_byte_o <= '0;
      done_o     <= 1'b0;
      err_o      <= 1'b0;
    end else begin
      eng_req_o <= 1'b0;
      done_o    <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (start_i) begin
            eng_req_o <= 1'b1;
            eng_op_o  <= OP_RESET;
            err_o     <= 1'b0;
            state     <= ST_WAIT_RST;
          end
        end
        ST_WAIT_RST: begin
          if (eng_done_i) begin
            if (!eng_presence_i) begin
              done_o <= 1'b1;
              err_o  <= 1'b1;
              state  <= ST_IDLE;
            end else begin
              eng_req_o  <= 1'b1;
              eng_op_o   <= OP_BYTE;
              eng_byte_o <= pick_byte_i;
              idx        <= nxt_idx_o;
              state      <= ST_WAIT_BYTE;
            end
          end
        end
        ST_WAIT_BYTE: begin
          if (eng_done_i) begin
            if (idx == last_idx_i) begin
              done_o <= 1'b1;
              state  <= ST_IDLE;
            end else begin
              eng_req_o  <= 1'b1;
              eng_byte_o <= pick_byte_i;
              idx        <= nxt_idx_o;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R7: requests are single-cycle pulses
  p_req_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    eng_req_o |=> !eng_req_o);

  // R7: a request follows only a start or an engine completion
  p_req_cause_r7: assert property (@(posedge clk) disable iff (rst)
    eng_req_o |-> ($past(start_i) || $past(eng_done_i)));

  // R1: the request leaving idle is a reset
  p_first_reset_r1: assert property (@(posedge clk) disable iff (rst)
    (eng_req_o && $past(state == ST_IDLE)) |-> (eng_op_o == OP_RESET));

  // R8: completion is a single-cycle pulse
  p_done_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  // R2: an error ending follows a completion without presence
  p_fail_cause_r2: assert property (@(posedge clk) disable iff (rst)
    (done_o && err_o) |-> $past(eng_done_i && !eng_presence_i));

endmodule

// File: rtl/bus_addr_seq.sv
module bus_addr_seq
  import bus_addr_seq_pkg::*;
#(
  parameter int CNT_W    = 8,
  parameter int ID_BYTES = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  start_i,
  input  logic                  mode_i,
  input  logic [CNT_W-1:0]      dev_count_i,
  input  logic [8*ID_BYTES-1:0] dev_id_i,
  output logic                  eng_req_o,
  output logic                  eng_op_o,
  output logic [7:0]            eng_byte_o,
  input  logic                  eng_done_i,
  input  logic                  eng_presence_i,
  output logic                  done_o,
  output logic                  err_o
);

  localparam int ID_W  = 8 * ID_BYTES;
  localparam int IDX_W = $clog2(ID_BYTES + 2);

  logic             idle;
  logic             cap_mode;
  logic [CNT_W-1:0] cap_count;
  logic [ID_W-1:0]  cap_id;
  logic [7:0]       cmd;
  logic             send_id;
  logic [IDX_W-1:0] last_idx;
  logic [IDX_W-1:0] nxt_idx;
  logic [7:0]       pick_byte;

  always_ff @(posedge clk) begin
    if (rst) begin
      cap_mode  <= MODE_SELECT;
      cap_count <= '0;
      cap_id    <= '0;
    end else if (start_i && idle) begin
      cap_mode  <= mode_i;
      cap_count <= dev_count_i;
      cap_id    <= dev_id_i;
    end
  end

  assign last_idx = send_id ? IDX_W'(ID_BYTES) : '0;

  bus_addr_plan #(.CNT_W(CNT_W)) u_plan (
    .mode_i    (cap_mode),
    .count_i   (cap_count),
    .cmd_o     (cmd),
    .send_id_o (send_id)
  );

  bus_addr_byte_pick #(.ID_BYTES(ID_BYTES), .IDX_W(IDX_W)) u_pick (
    .cmd_i  (cmd),
    .id_i   (cap_id),
    .idx_i  (nxt_idx),
    .byte_o (pick_byte)
  );

  bus_addr_ctrl #(.IDX_W(IDX_W)) u_ctrl (
    .clk            (clk),
    .rst            (rst),
    .start_i        (start_i),
    .eng_done_i     (eng_done_i),
    .eng_presence_i (eng_presence_i),
    .last_idx_i     (last_idx),
    .pick_byte_i    (pick_byte),
    .nxt_idx_o      (nxt_idx),
    .idle_o         (idle),
    .eng_req_o      (eng_req_o),
    .eng_op_o       (eng_op_o),
    .eng_byte_o     (eng_byte_o),
    .done_o         (done_o),
    .err_o          (err_o)
  );

  // R6: captured request stays put while a sequence runs
  p_capture_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (!idle && $past(!idle)) |-> ($stable(cap_mode) && $stable(cap_count) && $stable(cap_id)));

endmodule

// File: tb/bus_addr_seq_tb.sv
module bus_addr_seq_tb;

  localparam int CNT_W    = 8;
  localparam int ID_BYTES = 8;
  localparam int NV       = 9;

  // {mode, count, presence, exp_err, exp_nbytes, exp_cmd}
  localparam logic [22:0] VEC [NV] = '{
    {1'b0, 8'd1,   1'b1, 1'b0, 4'd1, 8'hCC},
    {1'b0, 8'd2,   1'b1, 1'b0, 4'd9, 8'h55},
    {1'b0, 8'd0,   1'b1, 1'b0, 4'd9, 8'h55},
    {1'b0, 8'd255, 1'b1, 1'b0, 4'd9, 8'h55},
    {1'b1, 8'd1,   1'b1, 1'b0, 4'd1, 8'hCC},
    {1'b1, 8'd2,   1'b1, 1'b0, 4'd1, 8'hA5},
    {1'b1, 8'd0,   1'b1, 1'b0, 4'd1, 8'hCC},
    {1'b0, 8'd2,   1'b0, 1'b1, 4'd0, 8'h00},
    {1'b1, 8'd5,   1'b0, 1'b1, 4'd0, 8'h00}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start_i = 1'b0;
  logic mode_i = 1'b0;
  logic [CNT_W-1:0] dev_count_i = '0;
  logic [8*ID_BYTES-1:0] dev_id_i = '0;
  logic eng_req_o, eng_op_o, done_o, err_o;
  logic [7:0] eng_byte_o;
  logic eng_done_i = 1'b0;
  logic eng_presence_i = 1'b0;

  always #4 clk = ~clk;

  bus_addr_seq #(.CNT_W(CNT_W), .ID_BYTES(ID_BYTES)) u_dut (
    .clk(clk), .rst(rst), .start_i(start_i), .mode_i(mode_i),
    .dev_count_i(dev_count_i), .dev_id_i(dev_id_i),
    .eng_req_o(eng_req_o), .eng_op_o(eng_op_o), .eng_byte_o(eng_byte_o),
    .eng_done_i(eng_done_i), .eng_presence_i(eng_presence_i),
    .done_o(done_o), .err_o(err_o)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  int   lat = 2;
  int   busy_cnt = 0;
  int   n_rec = 0;
  int   overlap = 0;
  logic rec_op [16];
  logic [7:0] rec_byte [16];
  bit   model_on = 1;

  // engine model: answers each request after lat cycles
  initial begin
    forever begin
      @(negedge clk);
      if (model_on) begin
        eng_done_i = 1'b0;
        if (busy_cnt > 0) begin
          busy_cnt--;
          if (busy_cnt == 0) eng_done_i = 1'b1;
        end
        if (eng_req_o) begin
          if (busy_cnt > 0) overlap++;
          if (n_rec < 16) begin
            rec_op[n_rec]   = eng_op_o;
            rec_byte[n_rec] = eng_byte_o;
          end
          n_rec++;
          busy_cnt = lat;
        end
      end
    end
  end

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  int extra_done;

  task automatic run_seq(input logic m, input logic [7:0] c, input logic p,
                         input logic [63:0] id, input bit poke_start);
    int t;
    n_rec = 0;
    overlap = 0;
    @(negedge clk);
    mode_i = m; dev_count_i = c; dev_id_i = id; eng_presence_i = p;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    mode_i = ~m; dev_count_i = ~c; dev_id_i = ~id;
    t = 0;
    while (!done_o && t < 2000) begin
      if (poke_start && t == 3) start_i = 1'b1;
      else start_i = 1'b0;
      @(negedge clk);
      t++;
    end
    start_i = 1'b0;
    extra_done = 0;
  endtask

  task automatic tail_done();
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      if (done_o) extra_done++;
    end
  endtask

  logic [63:0] id_v;

  initial begin
    rst = 1'b1;
    repeat (3) @(negedge clk);
    check(done_o == 0 && err_o == 0 && eng_req_o == 0, "R8 reset state",
          {done_o, err_o, eng_req_o}, 0);
    rst = 1'b0;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      logic m; logic [7:0] c; logic p; logic ee; logic [3:0] en; logic [7:0] ec;
      {m, c, p, ee, en, ec} = VEC[i];
      id_v = 64'h0F1E2D3C4B5A6978 + 64'h1111111111111111 * i;
      run_seq(m, c, p, id_v, 1'b0);
      check(done_o == 1, "R8 done seen", done_o, 1);
      check(err_o == ee, "R2 error flag", err_o, ee);
      check(n_rec >= 1 && rec_op[0] == 1'b0, "R1 reset first", rec_op[0], 0);
      check(n_rec == int'(en) + 1, "R3/R4/R5 request count", n_rec - 1, en);
      if (en != 0) begin
        check(rec_op[1] == 1'b1 && rec_byte[1] == ec,
              m ? "R5 command byte" : (en == 1 ? "R3 command byte" : "R4 command byte"),
              rec_byte[1], ec);
      end
      if (en == 9) begin
        for (int b = 0; b < 8; b++)
          check(rec_byte[b+2] == id_v[8*b +: 8], "R4 id byte order", rec_byte[b+2], id_v[8*b +: 8]);
      end
      tail_done();
      check(extra_done == 0, "R8 single done pulse", extra_done, 0);
      check(err_o == ee, "R8 err holds", err_o, ee);
      check(overlap == 0, "R7 one outstanding", overlap, 0);
    end

    // R7: long engine latency, still one request at a time
    lat = 7;
    id_v = 64'h8899AABBCCDDEEFF;
    run_seq(1'b0, 8'd3, 1'b1, id_v, 1'b0);
    check(n_rec == 10 && overlap == 0, "R7 slow engine", n_rec, 10);
    check(rec_byte[9] == 8'h88, "R4 last id byte slow", rec_byte[9], 8'h88);
    lat = 2;

    // R6: start during a running sequence is ignored; inputs flipped after capture
    run_seq(1'b0, 8'd2, 1'b1, 64'h0706050403020100, 1'b1);
    check(n_rec == 10, "R6 busy start ignored", n_rec, 10);
    check(rec_byte[1] == 8'h55 && rec_byte[2] == 8'h00 && rec_byte[9] == 8'h07,
          "R6 captured inputs", {rec_byte[1], rec_byte[2], rec_byte[9]}, 24'h550007);
    tail_done();
    check(n_rec == 10 && extra_done == 0, "R6 no extra sequence", n_rec, 10);

    // R7: stray engine completion while idle has no effect
    model_on = 0;
    n_rec = 0;
    @(negedge clk); eng_done_i = 1'b1; eng_presence_i = 1'b0;
    @(negedge clk); eng_done_i = 1'b0;
    extra_done = 0;
    for (int k = 0; k < 4; k++) begin
      if (done_o || eng_req_o) extra_done++;
      @(negedge clk);
    end
    check(extra_done == 0, "R7 stray done ignored", extra_done, 0);
    check(err_o == 0, "R8 err unchanged by stray done", err_o, 0);
    model_on = 1;

    if (!finished) begin
      finished = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

endmodule